// File: doc/BRIEF.md
# Dynamic ID Port Sequencer

This block sits on the host side of an ISA-style I/O bus and listens to every write cycle. It has no fixed address. While idle it watches the sixteen addresses of the form 0x1x0. The first zero byte written to any of them fixes that address as its ID port. From then on it compares each byte written to the ID port with an expected key stream. When the whole stream has arrived, a final 0xFF written to the port moves the adapter into its activated state.

The key stream is not stored as a list. It is generated from two parameters: a start byte and a feedback pattern. A parameter chooses how the stream is held. It can be an elaborated lookup table indexed by the sequence position, or a running shift-register generator that steps along with the sequence. The two forms behave the same at the ports.

Top module: `idport_seq`

## Requirements
- R1: After reset `seq_state` is 0 (waiting), `id_port` is 0, and `seq_match` and `activated` are 0.
- R2: In the waiting state, a write only counts when `io_wr` is high, address bits [15:8] equal 0x01, bits [3:0] equal 0 and the data is 0x00. Bits [7:4] may take any value. Any other write, and any cycle without `io_wr`, leaves the state unchanged.
- R3: A counting write in the waiting state latches its address on `id_port` and moves `seq_state` to 1 (tracking), with the tracker at position 0.
- R4: Once a port is latched, writes to any other address change neither `id_port` nor the state. The port is held until reset.
- R5: In tracking, a write to the ID port carrying the expected byte for the current position advances the tracker. The byte for the last position (SEQ_LEN-1) moves `seq_state` to 2 (matched) and raises `seq_match`.
- R6: In tracking, a write to the ID port with a nonzero byte other than the expected one sends the tracker back to position 0, and the port is kept.
- R7: A zero written to the ID port while tracking returns the tracker to position 0, and the state stays tracking.
- R8: In the matched state, 0xFF written to the ID port moves `seq_state` to 3 (activated) and raises `activated`. Any other byte written to the port there, zero included, returns the block to tracking at position 0.
- R9: The activated state is kept until reset. Every later write is ignored, including a zero to the ID port or to any 0x1x0 address.
- R10: The key byte at position 0 is SEQ_SEED (default 0xFF). Each next byte is the previous byte shifted left by one with a 0 entering bit 0, XORed with SEQ_POLY (default 0xCF) when the previous byte's bit 7 was 1. The default length is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data byte |
| io_wr | input | 1 | Write strobe, one cycle per write |
| id_port | output | 16 | Latched ID port address, 0 until latched |
| seq_state | output | 2 | 0 waiting, 1 tracking, 2 matched, 3 activated |
| seq_match | output | 1 | Full key stream received |
| activated | output | 1 | Adapter activated |

## Verification
The assertions check, on every cycle, that the latched port never moves once it is set and that the activated state is never left. They also check that entering tracking needs a zero write, that activation needs a 0xFF write to the port, that the position index stays in range, and that a restart returns the key stream to its start. Only the bench scenarios can show the rest: that the whole key stream, with its generated contents, leads to a match at exactly the last byte, and that mismatches and zeros in the middle really restart the comparison. The bench does this by later running the full stream again. Its random phase compares every write against an independent model of the rules.

// File: rtl/idseq_pkg.sv
package idseq_pkg;

   typedef enum logic [1:0] {
      ST_WAIT    = 2'd0,
      ST_TRACK   = 2'd1,
      ST_MATCHED = 2'd2,
      ST_ACTIVE  = 2'd3
   } seq_state_e;

   localparam logic [7:0] ACT_BYTE = 8'hFF;

   // one step of the key-stream generator
   function automatic logic [7:0] key_step(input logic [7:0] cur, input logic [7:0] poly);
      logic [7:0] nxt;
      nxt = {cur[6:0], 1'b0};
      if (cur[7]) nxt = nxt ^ poly;
      return nxt;
   endfunction

   // key byte at position n, computed from the start byte
   function automatic logic [7:0] key_at(input logic [7:0] seed, input logic [7:0] poly,
                                         input int n);
      logic [7:0] v;
      v = seed;
      for (int i = 0; i < n; i++) v = key_step(v, poly);
      return v;
   endfunction

endpackage

// File: rtl/idseq_addr_dec.sv
module idseq_addr_dec #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int HI_W = ADDR_W - 8;
   localparam logic [HI_W-1:0] HI_VAL = HI_W'(1);

   generate
      if (ADDR_W < 12) begin : g_bad_w
         $error("idseq_addr_dec: ADDR_W must be at least 12");
      end
   endgenerate

   // bits [7:4] are free; the page and the low nibble are fixed
   assign hit = (addr[ADDR_W-1:8] == HI_VAL) && (addr[3:0] == 4'h0);

endmodule

// File: rtl/idseq_key_rom.sv
module idseq_key_rom #(
   parameter int         SEQ_LEN   = 255,
   parameter logic [7:0] SEQ_SEED  = 8'hFF,
   parameter logic [7:0] SEQ_POLY  = 8'hCF,
   parameter bit         USE_TABLE = 1'b1,
   localparam int        IDX_W     = $clog2(SEQ_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             adv,
   input  logic             restart,
   output logic [7:0]       key
);
   generate
      if (SEQ_LEN < 2 || SEQ_LEN > 1024) begin : g_bad_len
         $error("idseq_key_rom: SEQ_LEN must lie in 2..1024");
      end
      if (SEQ_SEED == 8'h00 || SEQ_POLY[0] != 1'b1) begin : g_bad_key
         $error("idseq_key_rom: seed must be nonzero and poly bit 0 set");
      end

      if (USE_TABLE) begin : g_table
         logic [7:0] tbl [SEQ_LEN];
         for (genvar g = 0; g < SEQ_LEN; g++) begin : g_ent
            assign tbl[g] = idseq_pkg::key_at(SEQ_SEED, SEQ_POLY, g);
         end
         assign key = tbl[idx];

         AST_RESTART_IDX: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> (idx == '0)); // R6
         AST_ADV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !restart) |=> (idx != '0)); // R5
      end else begin : g_lfsr
         logic [7:0] cur_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cur_q <= SEQ_SEED;
            else if (restart) cur_q <= SEQ_SEED;
            else if (adv)     cur_q <= idseq_pkg::key_step(cur_q, SEQ_POLY);
         end
         assign key = cur_q;

         AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n)
            (idx == '0) |-> (key == SEQ_SEED)); // R10
         AST_NONZERO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
            (adv || restart) |=> (key != 8'h00)); // R10
      end
   endgenerate

endmodule

// File: rtl/idseq_fsm.sv
module idseq_fsm
   import idseq_pkg::*;
#(
   parameter int  ADDR_W  = 16,
   parameter int  SEQ_LEN = 255,
   localparam int IDX_W   = $clog2(SEQ_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic              dec_hit,
   input  logic [7:0]        key,
   output logic [IDX_W-1:0]  idx,
   output logic              adv,
   output logic              restart,
   output logic [ADDR_W-1:0] port,
   output seq_state_e        state
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

   seq_state_e        st_q, st_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [ADDR_W-1:0] port_q, port_d;
   logic              port_wr, zero_wr;

   assign port_wr = io_wr && (io_addr == port_q);
   assign zero_wr = (io_wdata == 8'h00);

   always_comb begin
      st_d    = st_q;
      idx_d   = idx_q;
      port_d  = port_q;
      adv     = 1'b0;
      restart = 1'b0;
      unique case (st_q)
         ST_WAIT: begin
            if (io_wr && dec_hit && zero_wr) begin
               port_d  = io_addr;
               st_d    = ST_TRACK;
               idx_d   = '0;
               restart = 1'b1;
            end
         end
         ST_TRACK: begin
            if (port_wr) begin
               if (zero_wr) begin
                  idx_d   = '0;
                  restart = 1'b1;
               end else if (io_wdata == key) begin
                  adv = 1'b1;
                  if (idx_q == LAST_IDX) st_d  = ST_MATCHED;
                  else                   idx_d = idx_q + 1'b1;
               end else begin
                  idx_d   = '0;
                  restart = 1'b1;
               end
            end
         end
         ST_MATCHED: begin
            if (port_wr) begin
               if (io_wdata == ACT_BYTE) begin
                  st_d = ST_ACTIVE;
               end else begin
                  st_d    = ST_TRACK;
                  idx_d   = '0;
                  restart = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_WAIT;
         idx_q  <= '0;
         port_q <= '0;
      end else begin
         st_q   <= st_d;
         idx_q  <= idx_d;
         port_q <= port_d;
      end
   end

   assign idx   = idx_q;
   assign port  = port_q;
   assign state = st_q;

   AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_WAIT) |=> $stable(port_q)); // R4
   AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACTIVE) |=> (st_q == ST_ACTIVE)); // R9
   AST_LATCH_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRACK && $past(st_q) == ST_WAIT) |-> ($past(io_wdata) == 8'h00 && $past(io_wr))); // R3
   AST_ACT_ON_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACTIVE && $past(st_q) == ST_MATCHED) |-> ($past(io_wr) && $past(io_wdata) == ACT_BYTE)); // R8
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX); // R5
   AST_ZERO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TRACK && port_wr && zero_wr) |=> (st_q == ST_TRACK && idx_q == '0)); // R7

endmodule

// File: rtl/idport_seq.sv
module idport_seq #(
   parameter int         ADDR_W    = 16,
   parameter int         SEQ_LEN   = 255,
   parameter logic [7:0] SEQ_SEED  = 8'hFF,
   parameter logic [7:0] SEQ_POLY  = 8'hCF,
   parameter bit         USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   output logic [ADDR_W-1:0] id_port,
   output logic [1:0]        seq_state,
   output logic              seq_match,
   output logic              activated
);
   import idseq_pkg::*;

   localparam int IDX_W = $clog2(SEQ_LEN);

   logic             dec_hit;
   logic [7:0]       key;
   logic [IDX_W-1:0] idx;
   logic             adv, restart;
   seq_state_e       state;

   idseq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (io_addr),
      .hit  (dec_hit)
   );

   idseq_key_rom #(
      .SEQ_LEN   (SEQ_LEN),
      .SEQ_SEED  (SEQ_SEED),
      .SEQ_POLY  (SEQ_POLY),
      .USE_TABLE (USE_TABLE)
   ) u_rom (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (idx),
      .adv     (adv),
      .restart (restart),
      .key     (key)
   );

   idseq_fsm #(.ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .io_wr    (io_wr),
      .dec_hit  (dec_hit),
      .key      (key),
      .idx      (idx),
      .adv      (adv),
      .restart  (restart),
      .port     (id_port),
      .state    (state)
   );

   assign seq_state = state;
   assign seq_match = (state == ST_MATCHED);
   assign activated = (state == ST_ACTIVE);

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_match && activated)); // R8
   AST_PORT_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state != 2'd0) |-> (id_port[3:0] == 4'h0 && id_port[ADDR_W-1:8] == 1)); // R2

endmodule

// File: tb/idport_seq_bench.sv
module idport_seq_bench;
   localparam int LEN = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic [15:0] id_port;
   logic [1:0]  seq_state;
   logic        seq_match, activated;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // independent model of the rules
   logic [7:0]  seq [LEN];
   int          m_state, m_idx;
   logic [15:0] m_port;

   always #5 clk = ~clk;

   idport_seq u_idport_seq (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
      .id_port(id_port), .seq_state(seq_state), .seq_match(seq_match), .activated(activated)
   );

   function automatic logic [7:0] next_key(input logic [7:0] v);
      // R10: shift left, XOR 0xCF when old bit 7 set
      return v[7] ? ({v[6:0], 1'b0} ^ 8'hCF) : {v[6:0], 1'b0};
   endfunction

   function automatic bit decodes(input logic [15:0] a);
      return (a[15:8] == 8'h01) && (a[3:0] == 4'h0);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_state = 0; m_idx = 0; m_port = '0;
   endtask

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      case (m_state)
         0: if (decodes(a) && d == 8'h00) begin m_port = a; m_state = 1; m_idx = 0; end
         1: if (a == m_port) begin
               if (d == 8'h00)            m_idx = 0;
               else if (d == seq[m_idx]) begin
                  if (m_idx == LEN-1) m_state = 2; else m_idx++;
               end else                   m_idx = 0;
            end
         2: if (a == m_port) begin
               if (d == 8'hFF) m_state = 3; else begin m_state = 1; m_idx = 0; end
            end
         default: ;
      endcase
   endtask

   task automatic check_all(input string req);
      chk({req, " state"}, 32'(seq_state), 32'(m_state));
      chk({req, " port"},  32'(id_port),   32'(m_port));
      chk({req, " match"}, 32'(seq_match), 32'(m_state == 2));
      chk({req, " act"},   32'(activated), 32'(m_state == 3));
   endtask

   // one write cycle; result visible at the following falling edge
   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic send_seq(input logic [15:0] p, input int upto);
      for (int i = 0; i < upto; i++) wr(p, seq[i]);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; io_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      seq[0] = 8'hFF;
      for (int i = 1; i < LEN; i++) seq[i] = next_key(seq[i-1]);
      void'($urandom(32'd7391));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2: writes that must not latch
      wr(16'h0130, 8'h55);  check_all("R2 nonzero");
      wr(16'h0131, 8'h00);  check_all("R2 low nibble");
      wr(16'h0230, 8'h00);  check_all("R2 page");
      @(negedge clk); io_addr = 16'h0150; io_wdata = 8'h00;
      @(negedge clk);       check_all("R2 no strobe");

      // R3
      wr(16'h01F0 & 16'h0150, 8'h00); check_all("R3 latch");
      chk("R3 port value", 32'(id_port), 32'h0150);

      // R4: other 0x1x0 addresses ignored
      wr(16'h0120, 8'h00);  check_all("R4 zero elsewhere");
      wr(16'h0160, seq[0]); check_all("R4 key elsewhere");

      // R6: mismatch partway, then full stream must still match at the end
      send_seq(16'h0150, 10);
      wr(16'h0150, seq[10] ^ 8'h01); check_all("R6 mismatch");
      send_seq(16'h0150, LEN-1);     check_all("R5 before last");
      chk("R5 not yet", 32'(seq_match), 32'h0);
      wr(16'h0150, seq[LEN-1]);      check_all("R5 R10 full stream");
      chk("R5 match flag", 32'(seq_match), 32'h1);

      // R8: wrong byte after match returns to tracking
      wr(16'h0150, 8'h12); check_all("R8 non-FF");
      chk("R8 back to track", 32'(seq_state), 32'd1);

      // R7: zero in the middle restarts
      send_seq(16'h0150, 40);
      wr(16'h0150, 8'h00); check_all("R7 zero");
      send_seq(16'h0150, LEN); check_all("R7 rematch");
      chk("R7 matched", 32'(seq_state), 32'd2);

      // R8: activation
      wr(16'h0150, 8'hFF); check_all("R8 activate");
      chk("R8 act flag", 32'(activated), 32'h1);

      // R9: all ignored once active
      wr(16'h0150, 8'h00); check_all("R9 zero port");
      wr(16'h0100, 8'h00); check_all("R9 zero other");
      wr(16'h0150, 8'h33); check_all("R9 byte");
      chk("R9 held", 32'(seq_state), 32'd3);

      // random phase against the model
      for (int round = 0; round < 4; round++) begin
         do_reset();
         @(negedge clk); check_all("R1 rereset");
         for (int n = 0; n < 300; n++) begin
            int sel;
            logic [15:0] a;
            logic [7:0]  d;
            sel = int'($urandom_range(0, 9));
            a = {8'h01, 4'($urandom_range(0, 15)), 4'h0};
            d = 8'($urandom);
            if (m_state == 0) begin
               if (sel < 3) d = 8'h00;
               if (sel == 9) a[0] = 1'b1;
            end else if (sel < 6) begin
               a = m_port;
               if (sel < 4)       d = seq[m_idx];
               else if (sel == 4) d = 8'h00;
            end else if (sel == 6 && m_state == 1) begin
               send_seq(m_port, LEN - m_idx > 60 ? 60 : LEN - m_idx);
               a = m_port;
               d = (m_state == 2) ? 8'hFF : seq[m_idx];
            end
            wr(a, d);
            check_all("R4 R6 R7 random");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule